// File: doc/BRIEF.md
# Routed level interrupt controller

This block gathers 32 level-sensitive interrupt sources and steers each one onto one of fifteen interrupt output lines, or onto none. Every source has its own enable bit in a mask word and its own 4-bit steering code. An output line is high while at least one source is high, enabled and steered to that line. The source levels are first passed through a two-stage synchronizer. Software can read them back as a status word.

Software reaches the block over a simple synchronous register port. The port has a byte address, a write strobe, a read strobe, write data and read data. The enable word sits at byte offset 0x00 and the status word at 0x04. Four steering words follow at 0x08, 0x0C, 0x10 and 0x14. Each steering word holds eight 4-bit codes. The steering words are packed in descending source order, so the lowest steering offset serves the highest-numbered sources. The output lines are registered.

Top module: `irq_router`

## Requirements
- R1: The source levels pass through two flip-flop stages. A read at offset 0x04 returns the synchronized levels, with source n in bit n.
- R2: Read data is registered. It shows the addressed word on the clock edge that samples the read strobe, and it holds its value while the read strobe is low.
- R3: The enable word at 0x00 is readable and writable. When bit n of this word is 0, source n reaches no output line.
- R4: Each steering word packs the codes of eight sources. 0x08 serves sources 24..31, 0x0C serves 16..23, 0x10 serves 8..15 and 0x14 serves 0..7. Source n uses bits [4*(n mod 8)+3 : 4*(n mod 8)] of its word, so source 31 uses bits 31:28 of 0x08. The steering words read back what was written.
- R5: Code 0 leaves a source unconnected. A code c in 1..15 drives output line c-1.
- R6: Output line k is a register. On each clock edge it loads the OR of all sources that are high (synchronized), enabled and carry code k+1. A level change at a source therefore shows at the output on the third rising edge after it. The output stays high for as long as such a source stays high.
- R7: Reset clears the enable word, every steering code, the read data and all output lines to zero.
- R8: A read from any offset other than the six mapped words returns zero, and misaligned offsets count as unmapped. A write to an unmapped offset, or to the status word, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lvl | input | 32 | Interrupt source levels, asynchronous |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_line | output | 15 | Interrupt output lines |

## Verification
The bench works through every steering code from 0 to 15 on a single source. A swapped or off-by-one decode would light the wrong line, and a wrong decode of code 0 would light a line for an unconnected source. It steers sources 31 and 0 through the first and last steering words and reads all four words back. A design that packed the words in ascending source order, or put the fields in the wrong nibbles, would show the source on the wrong line or fail the read-back.

The bench counts the cycles from a source edge to the output edge on both the rising and the falling side. A missing synchronizer stage, or an edge-triggered output, would show up there. It writes to the status word, to misaligned offsets and to offsets past the map, and then reads the enable and steering words back. A decoder that aliased those offsets would corrupt the enable or steering state.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC = 32,
  parameter int NOUT = 15,
  parameter int CW   = 4,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_lvl,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [NOUT-1:0] irq_line
);
  localparam int FPW = DW / CW;
  localparam int NRW = NSRC / FPW;
  localparam logic [AW-1:0] OFS_EN   = AW'(0);
  localparam logic [AW-1:0] OFS_STAT = AW'(4);
  localparam logic [AW-1:0] OFS_RT   = AW'(8);

  logic [NSRC-1:0]    sync1_q, stat_q, en_q;
  logic [CW-1:0]      code_q [NSRC];
  logic [NSRC*CW-1:0] code_flat;
  logic [NOUT-1:0]    line_d;
  logic [DW-1:0]      rd_word, rt_word;
  logic [AW-1:0]      rt_off;
  logic [AW-3:0]      rt_idx;

  assign rt_off = reg_addr - OFS_RT;
  assign rt_idx = rt_off[AW-1:2];

  wire hit_en   = reg_addr == OFS_EN;
  wire hit_stat = reg_addr == OFS_STAT;
  wire hit_rt   = reg_addr >= OFS_RT && reg_addr < OFS_RT + AW'(4*NRW) && reg_addr[1:0] == 2'b00;
  wire hit_any  = hit_en || hit_stat || hit_rt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      stat_q  <= '0;
    end else begin
      sync1_q <= src_lvl;
      stat_q  <= sync1_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else if (reg_wr && hit_en) en_q <= reg_wdata[NSRC-1:0];

  for (genvar n = 0; n < NSRC; n++) begin : g_code
    localparam int WRD = NRW - 1 - n / FPW;
    localparam int FLD = n % FPW;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) code_q[n] <= '0;
      else if (reg_wr && hit_rt && int'(rt_idx) == WRD) code_q[n] <= reg_wdata[FLD*CW +: CW];
    assign code_flat[n*CW +: CW] = code_q[n];
  end

  always_comb begin
    rt_word = '0;
    for (int i = 0; i < FPW; i++)
      rt_word[i*CW +: CW] = code_q[(NRW - 1 - int'(rt_idx)) * FPW + i];
  end

  always_comb begin
    rd_word = '0;
    if (hit_en)        rd_word[NSRC-1:0] = en_q;
    else if (hit_stat) rd_word[NSRC-1:0] = stat_q;
    else if (hit_rt)   rd_word = rt_word;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;

  always_comb begin
    line_d = '0;
    for (int n = 0; n < NSRC; n++)
      if (stat_q[n] && en_q[n] && code_q[n] != '0 && int'(code_q[n]) <= NOUT)
        line_d[int'(code_q[n]) - 1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_line <= '0;
    else irq_line <= line_d;

  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == '0 |=> irq_line == '0);
  a_r5_unrouted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    code_flat == '0 |=> irq_line == '0);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q == '0 |=> irq_line == '0);
  a_r3_en_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == OFS_EN |=> en_q == $past(reg_wdata[NSRC-1:0]));
  a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !hit_any |=> reg_rdata == '0);
  a_r8_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !hit_en && !hit_rt |=> $stable(en_q) && $stable(code_flat));
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [14:0] irq_line;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] en_m = '0;
  logic [3:0]  code_m [32];

  irq_router dut (.clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_line(irq_line));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [31:0] rt_word(int w);
    logic [31:0] v = '0;
    for (int i = 0; i < 8; i++) v[i*4 +: 4] = code_m[(3 - w) * 8 + i];
    return v;
  endfunction

  task automatic load_codes();
    for (int w = 0; w < 4; w++) wr(5'(8 + 4*w), rt_word(w));
  endtask

  function automatic logic [14:0] model(logic [31:0] s);
    logic [14:0] o = '0;
    for (int n = 0; n < 32; n++)
      if (s[n] && en_m[n] && code_m[n] != 0) o[code_m[n] - 1] = 1'b1;
    return o;
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R7 lines after reset", 32'(irq_line), 0);
    chk("R7 rdata after reset", reg_rdata, 0);
    rd(5'h00, d); chk("R7 enable after reset", d, 0);
    for (int w = 0; w < 4; w++) begin
      rd(5'(8 + 4*w), d); chk("R7 steering after reset", d, 0);
    end
    src_lvl = 32'hFFFF_FFFF; settle();
    chk("R7 lines stay low", 32'(irq_line), 0);
    src_lvl = '0; settle();
  endtask

  task automatic t_layout();
    logic [31:0] d;
    for (int n = 0; n < 32; n++) code_m[n] = 4'((n % 15) + 1);
    code_m[31] = 4'd3; code_m[0] = 4'd12;
    load_codes();
    for (int w = 0; w < 4; w++) begin
      rd(5'(8 + 4*w), d); chk("R4 steering readback", d, rt_word(w));
    end
    en_m = 32'hFFFF_FFFF; wr(5'h00, en_m);
    rd(5'h00, d); chk("R3 enable readback", d, en_m);
    src_lvl = 32'h8000_0000; settle();
    chk("R4 source 31 via bits 31:28 of 0x08", 32'(irq_line), 32'h4);
    src_lvl = 32'h0000_0001; settle();
    chk("R4 source 0 via bits 3:0 of 0x14", 32'(irq_line), 32'h800);
    src_lvl = '0; settle();
  endtask

  task automatic t_codes();
    for (int c = 0; c < 16; c++) begin
      code_m[5] = 4'(c); load_codes();
      src_lvl = 32'h20; settle();
      chk("R5 code to line", 32'(irq_line), c == 0 ? 0 : 32'(1) << (c - 1));
      src_lvl = '0; settle();
    end
  endtask

  task automatic t_mask();
    logic [31:0] d;
    en_m = 32'hFFFF_FFDF; wr(5'h00, en_m);
    rd(5'h00, d); chk("R3 enable readback", d, en_m);
    src_lvl = 32'h20; settle();
    chk("R3 disabled source blocked", 32'(irq_line), 0);
    en_m = 32'hFFFF_FFFF; wr(5'h00, en_m); settle();
    chk("R3 re-enabled source passes", 32'(irq_line), 32'(model(src_lvl)));
    src_lvl = '0; settle();
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); src_lvl = 32'h0000_0400;
    @(negedge clk); @(negedge clk);
    rd(5'h04, d); chk("R1 status shows level", d, 32'h400);
    src_lvl = '0; settle();
    @(negedge clk); src_lvl = 32'h0000_0400;
    @(negedge clk); @(negedge clk);
    chk("R6 not yet after two edges", 32'(irq_line), 0);
    @(negedge clk);
    chk("R6 high on third edge", 32'(irq_line), 32'(model(32'h400)));
    repeat (20) @(negedge clk);
    chk("R6 held while level high", 32'(irq_line), 32'(model(32'h400)));
    src_lvl = '0;
    @(negedge clk); @(negedge clk);
    chk("R6 still high after two edges", 32'(irq_line), 32'(model(32'h400)));
    @(negedge clk);
    chk("R6 low on third edge", 32'(irq_line), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(5'h04, 32'h1234_5678); wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h01, 32'h0); wr(5'h0A, 32'h0); wr(5'h1C, 32'h0);
    rd(5'h00, d); chk("R8 enable untouched", d, en_m);
    for (int w = 0; w < 4; w++) begin
      rd(5'(8 + 4*w), d); chk("R8 steering untouched", d, rt_word(w));
    end
    rd(5'h04, d); chk("R8 status write ignored", d, 0);
    rd(5'h1C, d); chk("R8 unmapped read zero", d, 0);
    rd(5'h09, d); chk("R8 misaligned read zero", d, 0);
    rd(5'h00, d);
    @(negedge clk); reg_addr = 5'h04; repeat (3) @(negedge clk);
    chk("R2 rdata holds without read", reg_rdata, en_m);
  endtask

  task automatic t_patterns();
    logic [31:0] lf = 32'hACE1_2345;
    for (int p = 0; p < 24; p++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      for (int n = 0; n < 32; n++) code_m[n] = 4'(lf >> (n % 29));
      load_codes();
      en_m = lf ^ 32'h5A5A_0F0F; wr(5'h00, en_m);
      src_lvl = {lf[15:0], lf[31:16]}; settle();
      chk("R6 mixed pattern", 32'(irq_line), 32'(model(src_lvl)));
    end
    src_lvl = '0; settle();
  endtask

  initial begin
    for (int n = 0; n < 32; n++) code_m[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_layout(); t_codes(); t_mask(); t_level(); t_unmapped(); t_patterns();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule